// File: doc/BRIEF.md
# Parity-Framed Read-Only Tag Transmitter

This block sends a fixed 64-bit identification frame, again and again, as a Manchester-coded modulation-control line. The frame is built from a 40-bit identifier. Nine start bits come first, all ones. The identifier follows as ten rows of four bits, and each row carries an even-parity bit. Four column parity bits come next, and a zero stop bit closes the frame. The parity layout means nine ones in a row can never appear after the start pattern, so a reader can find the frame boundary.

The clock is the one recovered from the RF field, and every bit lasts a parameterized number of those clocks (32 or 64). The reset is active-low and tied to power-good. The identifier is a static input, held by a tie-off or a constant. The output is registered. A high on the output turns the load switch on. There is no handshake: the line runs as long as power is present.

Top module: `tag_frame_tx`

## Requirements
- R1: While `rst_n` is low, `mod_out` is low.
- R2: On the first rising clock edge after `rst_n` goes high, `mod_out` shows the first half of frame bit 0. That bit is a 1, so the output is high.
- R3: Frame bits 0 to 8 are all 1.
- R4: Row r (0 to 9) sits at frame bits 9+5r to 9+5r+4. It carries `id_value[39-4r]`, `id_value[38-4r]`, `id_value[37-4r]` and `id_value[36-4r]` in that order, then their even-parity bit (the XOR of the four).
- R5: Frame bits 59+c (c = 0 to 3) hold the XOR of bit position c taken over all ten rows.
- R6: Frame bit 63 is 0.
- R7: Manchester coding. A 1 is high for the first half of the bit and low for the second. A 0 is low, then high.
- R8: Each bit lasts `CLKS_PER_BIT` clocks, and the half-bit boundary falls exactly after `CLKS_PER_BIT/2` clocks.
- R9: After bit 63, the next clock starts bit 0 again, with no gap, for as long as `rst_n` stays high.
- R10: `CLKS_PER_BIT` may be 32 or 64, and both produce the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rf | input | 1 | Clock recovered from the RF field |
| rst_n | input | 1 | Active-low power-good reset, asynchronous assert |
| id_value | input | 40 | Static identifier to transmit |
| mod_out | output | 1 | Modulation control, high means load switch on |

## Verification
Each identifier is compared against the bench's own model on every clock, at both bit rates at once, over two full frames. An all-zero identifier makes every parity bit 0, so only the start, stop and Manchester halves can shape the output. An all-ones identifier sets each row parity to 0 and each column parity to 0, even though the data bits are 1. Mixed patterns catch a swapped row order or column order, or a reversed bit order within a row. A value with only its end bits set checks that row 0 and row 9 land in the right places. Running a second frame checks that the output wraps back to the start with no gap. Resetting between identifiers checks the idle-low level and the first-edge start.

// File: rtl/tagtx_pkg.sv
package tagtx_pkg;
  localparam int ID_BITS    = 40;
  localparam int ROWS       = 10;
  localparam int COLS       = 4;
  localparam int HDR_BITS   = 9;
  localparam int ROW_BASE   = HDR_BITS;
  localparam int ROW_STRIDE = COLS + 1;
  localparam int COLP_BASE  = ROW_BASE + ROWS * ROW_STRIDE;
  localparam int STOP_POS   = COLP_BASE + COLS;
  localparam int FRAME_BITS = STOP_POS + 1;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef logic [ID_BITS-1:0]    id_t;
  typedef logic [FRAME_BITS-1:0] frame_t;
  typedef logic [IDX_W-1:0]      idx_t;
endpackage

// File: rtl/tagtx_frame_build.sv
module tagtx_frame_build
  import tagtx_pkg::*;
(
  input  id_t    id_value,
  output frame_t frame
);
  // frame[i] is the i-th bit on air
  logic [ROWS-1:0] col_bits [COLS];

  for (genvar h = 0; h < HDR_BITS; h++) begin : g_hdr
    assign frame[h] = 1'b1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] nib;
    assign nib = id_value[ID_BITS-1-COLS*r -: COLS];
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign frame[ROW_BASE + r*ROW_STRIDE + c] = nib[COLS-1-c];
      assign col_bits[c][r] = nib[COLS-1-c];
    end
    assign frame[ROW_BASE + r*ROW_STRIDE + COLS] = ^nib;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_cpar
    assign frame[COLP_BASE + c] = ^col_bits[c];
  end

  assign frame[STOP_POS] = 1'b0;
endmodule

// File: rtl/tagtx_sequencer.sv
module tagtx_sequencer
  import tagtx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 64
) (
  input  logic clk_rf,
  input  logic rst_n,
  output idx_t bit_idx,
  output logic second_half
);
  localparam int CYC_W = $clog2(CLKS_PER_BIT);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLKS_PER_BIT - 1);
  localparam logic [CYC_W-1:0] CYC_HALF = CYC_W'(CLKS_PER_BIT / 2);
  localparam idx_t IDX_LAST = IDX_W'(FRAME_BITS - 1);

  logic [CYC_W-1:0] cyc_q;
  idx_t             idx_q;

  always_ff @(posedge clk_rf or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      idx_q <= '0;
    end else if (cyc_q == CYC_LAST) begin
      cyc_q <= '0;
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  assign bit_idx     = idx_q;
  assign second_half = (cyc_q >= CYC_HALF);

  AST_BIT_HOLD: assert property (@(posedge clk_rf) disable iff (!rst_n)
    (cyc_q != CYC_LAST) |=> $stable(idx_q)); // R8
  AST_FRAME_WRAP: assert property (@(posedge clk_rf) disable iff (!rst_n)
    (idx_q == IDX_LAST && cyc_q == CYC_LAST) |=> (idx_q == '0)); // R9
endmodule

// File: rtl/tagtx_manchester.sv
module tagtx_manchester (
  input  logic clk_rf,
  input  logic rst_n,
  input  logic data_bit,
  input  logic second_half,
  output logic mod_q
);
  always_ff @(posedge clk_rf or negedge rst_n) begin
    if (!rst_n) mod_q <= 1'b0;
    else        mod_q <= data_bit ^ second_half;
  end

  AST_MID_FLIP: assert property (@(posedge clk_rf) disable iff (!rst_n)
    $rose(second_half) |=> (mod_q != $past(mod_q))); // R7
endmodule

// File: rtl/tag_frame_tx.sv
module tag_frame_tx
  import tagtx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 64
) (
  input  logic                clk_rf,
  input  logic                rst_n,
  input  logic [ID_BITS-1:0]  id_value,
  output logic                mod_out
);
  frame_t frame;
  idx_t   bit_idx;
  logic   second_half;
  logic   cur_bit;

  tagtx_frame_build u_build (
    .id_value (id_value),
    .frame    (frame)
  );

  tagtx_sequencer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_seq (
    .clk_rf      (clk_rf),
    .rst_n       (rst_n),
    .bit_idx     (bit_idx),
    .second_half (second_half)
  );

  assign cur_bit = frame[bit_idx];

  tagtx_manchester u_enc (
    .clk_rf      (clk_rf),
    .rst_n       (rst_n),
    .data_bit    (cur_bit),
    .second_half (second_half),
    .mod_q       (mod_out)
  );

  AST_START_HIGH: assert property (@(posedge clk_rf) disable iff (!rst_n)
    (bit_idx < idx_t'(HDR_BITS) && !second_half) |=> mod_out); // R3
  AST_STOP_LOW: assert property (@(posedge clk_rf) disable iff (!rst_n)
    (bit_idx == idx_t'(STOP_POS) && !second_half) |=> !mod_out); // R6
endmodule

// File: tb/tag_frame_tx_test.sv
`timescale 1ns/1ps
module tag_frame_tx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] id = '0;
  logic        out64, out32;
  int          n_tests = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  tag_frame_tx #(.CLKS_PER_BIT(64)) uut   (.clk_rf(clk), .rst_n(rst_n), .id_value(id), .mod_out(out64));
  tag_frame_tx #(.CLKS_PER_BIT(32)) uut32 (.clk_rf(clk), .rst_n(rst_n), .id_value(id), .mod_out(out32));

  function automatic logic exp_bit(input logic [39:0] v, input int idx);
    int k, r, c;
    logic p;
    if (idx < 9) return 1'b1;
    if (idx < 59) begin
      k = idx - 9; r = k / 5; c = k % 5;
      if (c < 4) return v[39 - 4*r - c];
      return v[39-4*r] ^ v[38-4*r] ^ v[37-4*r] ^ v[36-4*r];
    end
    if (idx < 63) begin
      c = idx - 59; p = 1'b0;
      for (int rr = 0; rr < 10; rr++) p ^= v[39 - 4*rr - c];
      return p;
    end
    return 1'b0;
  endfunction

  function automatic string tag_of(input int p, input int cpb);
    int b = (p / cpb) % 64;
    if (p == 0) return "R2";
    if (p >= 64*cpb) return "R9";
    if (b < 9) return "R3";
    if (b < 59) return "R4";
    if (b < 63) return "R5";
    return "R6";
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input int p);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pos=%0d actual=%b expected=%b", req, p, act, exp);
    end
  endtask

  task automatic run_id(input logic [39:0] v);
    int cpbs[2] = '{64, 32};
    logic e;
    @(negedge clk);
    rst_n = 1'b0;
    id = v;
    repeat (3) @(negedge clk);
    check(out64, 1'b0, "R1", -1);
    check(out32, 1'b0, "R1", -1);
    rst_n = 1'b1;
    for (int p = 0; p < 2*64*64; p++) begin
      @(negedge clk);
      for (int s = 0; s < 2; s++) begin
        // R7 R8 R10: bit value XOR second-half flag, per rate
        e = exp_bit(v, (p / cpbs[s]) % 64) ^ ((p % cpbs[s]) >= cpbs[s]/2);
        if (s == 0) check(out64, e, tag_of(p, 64), p);
        else if (p < 2*64*32) check(out32, e, tag_of(p, 32), p);
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    run_id(40'h00_0000_0000);
    run_id(40'hFF_FFFF_FFFF);
    run_id(40'h12_3456_789A);
    run_id(40'h80_0000_0001);
    run_id(40'hA5_C3_0F_E1_7B);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule